// File: doc/BRIEF.md
# Synchronous Burst NOR Flash Read Sequencer

This block runs one synchronous burst read from a 16-bit NOR flash each time it is started. All its timing is counted in cycles of the functional clock. A cycle counter (the "tick") starts at 0 in the first cycle after the start pulse. Chip select, address valid and output enable are asserted when the tick reaches programmed values. The device clock is derived from the functional clock through a divider, and it starts a programmed number of ticks into the read. The block runs with either a parallel address bus or a shared address/data bus.

Data words are sampled at a programmed first-access tick and then once every burst interval, until a burst of 4, 8 or 16 words is complete. Each word is returned with the flash address it came from, and that address sequence either wraps inside the aligned burst or runs linearly. A device WAIT line, of selectable polarity, can stall each sampling point. It is read either in the sampling cycle itself or one cycle ahead. A stall freezes the tick, so every later event of the read moves back by the same number of cycles. A done strobe marks the last word. Chip select then stays low for a programmed hold count before the block returns to idle.

Top module: `nor_burst_reader`

## Requirements
- R1: After reset, and whenever the block is idle, chip select, address valid and output enable are high (inactive), the device clock is low, the shared bus is not driven, and rd_valid, done and busy are low.
- R2: The divider code sets the device-clock ratio: 0 gives 1:1, 1 gives 1:2, and 2 or 3 give 1:4. The clock stays low until the tick reaches cfg_clk_act. Counting from the first such cycle as cycle 0, a 1:1 clock is high in the first half of every cycle from cycle 1 onward. A 1:2 clock is high in odd cycles. A 1:4 clock is high in cycles 2 and 3 of every group of four.
- R3: During the read, chip select is low from tick cfg_cs_on onward. Address valid is low for ticks in the range [cfg_adv_on, cfg_adv_off). Output enable is low from tick cfg_oe_on onward, unless it is held off by R11.
- R4: With cfg_adv_half set, the rising edge of address valid is delayed by half a functional clock. The line is still low in the first half of tick cfg_adv_off and high in the second half.
- R5: The first word is sampled at the end of the cycle with tick cfg_first. Each later word is sampled cfg_gap cycles after the previous one, with a gap code of 0 treated as 1. The length code gives the burst length: 0 gives 4 words, 1 gives 8, and 2 or 3 give 16. Each word appears on rd_data with a one-cycle rd_valid pulse in the cycle after it is sampled.
- R6: rd_addr of word i is the start address plus i. With cfg_wrap set, only the low log2(length) bits take part in the addition, so the sequence wraps inside the aligned burst.
- R7: WAIT means not ready when nor_wait equals cfg_wait_pol: 0 is active low, 1 is active high.
- R8: With cfg_wait_early at 0, the WAIT level in the sampling cycle decides the stall. With cfg_wait_early at 1, the level in the cycle before decides it.
- R9: A stalled sampling point takes no word and freezes the tick for one cycle. The sampling point and all later chip select, address valid, output enable and clock-start events move back by one cycle.
- R10: done pulses together with the rd_valid of the last word. Chip select and output enable stay low for exactly cfg_cs_hold further cycles and are high in the cycle after those.
- R11: With cfg_mux set, the shared bus carries the low 16 bits of the start address from tick 0 up to, but not including, tick cfg_adv_off + cfg_adv_half. Output enable stays high while the bus is driven. With cfg_mux clear, the shared bus is never driven.
- R12: A start pulse during a read is ignored: the addresses, data and timing of the read in progress do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | functional clock |
| rst_n | input | 1 | asynchronous reset, active low |
| start | input | 1 | begin a burst read when idle |
| start_addr | input | ADDR_W | word address of the first word |
| cfg_div | input | 2 | device clock divider code |
| cfg_clk_act | input | TIME_W | tick at which the device clock starts |
| cfg_cs_on | input | TIME_W | chip select assert tick |
| cfg_adv_on | input | TIME_W | address valid assert tick |
| cfg_adv_off | input | TIME_W | address valid deassert tick |
| cfg_adv_half | input | 1 | delay address valid deassert by half a cycle |
| cfg_oe_on | input | TIME_W | output enable assert tick |
| cfg_first | input | TIME_W | tick of the first sampling point |
| cfg_gap | input | TIME_W | cycles between burst words |
| cfg_cs_hold | input | TIME_W | chip select hold cycles after done |
| cfg_len | input | 2 | burst length code |
| cfg_wrap | input | 1 | wrap the address inside the burst |
| cfg_wait_pol | input | 1 | WAIT level meaning not ready |
| cfg_wait_early | input | 1 | WAIT applies one cycle ahead |
| cfg_mux | input | 1 | shared address/data bus |
| busy | output | 1 | read in progress |
| rd_valid | output | 1 | word strobe |
| rd_data | output | DATA_W | captured word |
| rd_addr | output | ADDR_W | flash address of the captured word |
| done | output | 1 | last word strobe |
| nor_clk | output | 1 | device clock |
| nor_cs_n | output | 1 | chip select |
| nor_adv_n | output | 1 | address valid |
| nor_oe_n | output | 1 | output enable |
| nor_addr | output | ADDR_W | parallel address |
| nor_ad_out | output | DATA_W | shared bus address phase value |
| nor_ad_oe | output | 1 | shared bus drive enable |
| nor_data_in | input | DATA_W | data from the flash |
| nor_wait | input | 1 | device WAIT |

## Verification
The hardest case to reach is a stall when WAIT is read one cycle ahead. The level that counts is the one driven in the cycle before a sampling point. A stall also pushes the later strobe edges and the clock start back. The bench drives a fresh random WAIT level in every cycle of bursts whose wrap, polarity, early mode and divider settings are also random. This covers back-to-back stalls, stalls at the very first word, and stalls that fall before the address-valid and output-enable ticks. A reference model in the bench follows the frozen tick cycle by cycle.

// File: rtl/nor_burst_reader.sv
module nor_burst_reader #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int TIME_W = 4,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [1:0]        cfg_div,
  input  logic [TIME_W-1:0] cfg_clk_act,
  input  logic [TIME_W-1:0] cfg_cs_on,
  input  logic [TIME_W-1:0] cfg_adv_on,
  input  logic [TIME_W-1:0] cfg_adv_off,
  input  logic              cfg_adv_half,
  input  logic [TIME_W-1:0] cfg_oe_on,
  input  logic [TIME_W-1:0] cfg_first,
  input  logic [TIME_W-1:0] cfg_gap,
  input  logic [TIME_W-1:0] cfg_cs_hold,
  input  logic [1:0]        cfg_len,
  input  logic              cfg_wrap,
  input  logic              cfg_wait_pol,
  input  logic              cfg_wait_early,
  input  logic              cfg_mux,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              done,
  output logic              nor_clk,
  output logic              nor_cs_n,
  output logic              nor_adv_n,
  output logic              nor_oe_n,
  output logic [ADDR_W-1:0] nor_addr,
  output logic [DATA_W-1:0] nor_ad_out,
  output logic              nor_ad_oe,
  input  logic [DATA_W-1:0] nor_data_in,
  input  logic              nor_wait
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_TAIL} state_t;

  state_t            st;
  logic [CNT_W-1:0]  tick, nxt;
  logic [4:0]        wcnt, words;
  logic [TIME_W-1:0] hold;
  logic [ADDR_W-1:0] base, cur, mask, cur_next;
  logic [1:0]        dcnt;
  logic              wait_q, run, run_neg, adv_comb_n, adv_neg;
  logic              nr_now, nr_eff, cap_pt, stall, take, last;
  logic [CNT_W-1:0]  gap_eff;

  assign words    = (cfg_len == 2'd0) ? 5'd4 : (cfg_len == 2'd1) ? 5'd8 : 5'd16;
  assign mask     = ADDR_W'(words) - ADDR_W'(1);
  assign cur_next = cfg_wrap ? ((cur & ~mask) | ((cur + ADDR_W'(1)) & mask)) : cur + ADDR_W'(1);
  assign gap_eff  = (cfg_gap == '0) ? CNT_W'(1) : CNT_W'(cfg_gap);

  assign nr_now = (nor_wait == cfg_wait_pol);
  assign nr_eff = cfg_wait_early ? wait_q : nr_now;
  assign cap_pt = (st == S_RUN) && (tick == nxt);
  assign stall  = cap_pt && nr_eff;
  assign take   = cap_pt && !nr_eff;
  assign last   = (wcnt == words - 5'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      tick     <= '0;
      nxt      <= '0;
      wcnt     <= '0;
      hold     <= '0;
      base     <= '0;
      cur      <= '0;
      wait_q   <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      rd_addr  <= '0;
      done     <= 1'b0;
    end else begin
      wait_q   <= nr_now;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_RUN;
          tick <= '0;
          nxt  <= CNT_W'(cfg_first);
          wcnt <= '0;
          base <= start_addr;
          cur  <= start_addr;
        end
        S_RUN: begin
          if (!stall) tick <= tick + CNT_W'(1);
          if (take) begin
            rd_valid <= 1'b1;
            rd_data  <= nor_data_in;
            rd_addr  <= cur;
            cur      <= cur_next;
            wcnt     <= wcnt + 5'd1;
            nxt      <= tick + gap_eff;
            if (last) begin
              done <= 1'b1;
              st   <= S_TAIL;
              hold <= cfg_cs_hold;
            end
          end
        end
        S_TAIL: begin
          if (hold == '0) st <= S_IDLE;
          else hold <= hold - TIME_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign run = ((st == S_RUN) && (tick >= CNT_W'(cfg_clk_act))) || (st == S_TAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt <= '0;
    else if (run) dcnt <= dcnt + 2'd1;
    else dcnt <= '0;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_neg <= 1'b0;
      adv_neg <= 1'b1;
    end else begin
      run_neg <= run;
      adv_neg <= adv_comb_n;
    end
  end

  always_comb begin
    case (cfg_div)
      2'd0:    nor_clk = clk & run & run_neg;
      2'd1:    nor_clk = run & dcnt[0];
      default: nor_clk = run & dcnt[1];
    endcase
  end

  assign adv_comb_n = !((st == S_RUN) && (tick >= CNT_W'(cfg_adv_on)) && (tick < CNT_W'(cfg_adv_off)));
  assign nor_adv_n  = adv_comb_n & (!cfg_adv_half | adv_neg);
  assign nor_ad_oe  = cfg_mux && (st == S_RUN) && (tick < CNT_W'(cfg_adv_off) + CNT_W'(cfg_adv_half));
  assign nor_ad_out = nor_ad_oe ? base[DATA_W-1:0] : '0;
  assign nor_cs_n   = !(((st == S_RUN) && (tick >= CNT_W'(cfg_cs_on))) || (st == S_TAIL));
  assign nor_oe_n   = !((((st == S_RUN) && (tick >= CNT_W'(cfg_oe_on))) || (st == S_TAIL)) && !nor_ad_oe);
  assign nor_addr   = base;
  assign busy       = (st != S_IDLE);

  AST_DONE_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n) done |-> rd_valid && wcnt == words); // R10
  AST_STALL_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n) stall |=> !rd_valid && $stable(nor_cs_n)); // R9
  AST_WRAP_INSIDE: assert property (@(posedge clk) disable iff (!rst_n) (rd_valid && cfg_wrap) |-> ((rd_addr ^ base) & ~mask) == '0); // R6
  AST_CLK_QUIET: assert property (@(posedge clk) disable iff (!rst_n) (st == S_IDLE && $past(st) == S_IDLE) |-> !nor_clk && nor_cs_n); // R1
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (st != S_IDLE && start) |=> $stable(base)); // R12
  AST_WORD_LIMIT: assert property (@(posedge clk) disable iff (!rst_n) rd_valid |-> wcnt != 5'd0 && wcnt <= words); // R5

endmodule

// File: tb/test_nor_burst_reader.sv
module test_nor_burst_reader;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int TW = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [1:0] cfg_div = '0, cfg_len = '0;
  logic [TW-1:0] cfg_clk_act = '0, cfg_cs_on = '0, cfg_adv_on = '0, cfg_adv_off = '0;
  logic [TW-1:0] cfg_oe_on = '0, cfg_first = '0, cfg_gap = '0, cfg_cs_hold = '0;
  logic cfg_adv_half = 1'b0, cfg_wrap = 1'b0, cfg_wait_pol = 1'b0, cfg_wait_early = 1'b0, cfg_mux = 1'b0;
  logic busy, rd_valid, done, nor_clk, nor_cs_n, nor_adv_n, nor_oe_n, nor_ad_oe;
  logic [DW-1:0] rd_data, nor_ad_out;
  logic [AW-1:0] rd_addr, nor_addr;
  logic [DW-1:0] nor_data_in = '0;
  logic nor_wait = 1'b1;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  nor_burst_reader i_nor_burst_reader (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .cfg_div(cfg_div), .cfg_clk_act(cfg_clk_act), .cfg_cs_on(cfg_cs_on),
    .cfg_adv_on(cfg_adv_on), .cfg_adv_off(cfg_adv_off), .cfg_adv_half(cfg_adv_half),
    .cfg_oe_on(cfg_oe_on), .cfg_first(cfg_first), .cfg_gap(cfg_gap), .cfg_cs_hold(cfg_cs_hold),
    .cfg_len(cfg_len), .cfg_wrap(cfg_wrap), .cfg_wait_pol(cfg_wait_pol),
    .cfg_wait_early(cfg_wait_early), .cfg_mux(cfg_mux), .busy(busy), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_addr(rd_addr), .done(done), .nor_clk(nor_clk), .nor_cs_n(nor_cs_n),
    .nor_adv_n(nor_adv_n), .nor_oe_n(nor_oe_n), .nor_addr(nor_addr), .nor_ad_out(nor_ad_out),
    .nor_ad_oe(nor_ad_oe), .nor_data_in(nor_data_in), .nor_wait(nor_wait)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_at(input int c, input int salt);
    return DW'((c * 40503 + salt * 977 + 12345) & 16'hFFFF);
  endfunction

  function automatic logic [AW-1:0] addr_of(input logic [AW-1:0] b, input int i, input int n, input bit wr);
    logic [AW-1:0] m;
    m = AW'(n - 1);
    if (wr) return (b & ~m) | ((b + AW'(i)) & m);
    return b + AW'(i);
  endfunction

  task automatic idle_checks(input string tag);
    check({tag, " R1 cs"}, nor_cs_n, 1);
    check({tag, " R1 adv"}, nor_adv_n, 1);
    check({tag, " R1 oe"}, nor_oe_n, 1);
    check({tag, " R1 clk"}, nor_clk, 0);
    check({tag, " R1 ad_oe"}, nor_ad_oe, 0);
    check({tag, " R1 valid"}, rd_valid, 0);
    check({tag, " R1 busy"}, busy, 0);
  endtask

  task automatic burst(input logic [AW-1:0] a, input int stall_pct, input int salt);
    int n, gap, phase, tick_e, cand, widx, tail_left, run_start, rc, nstall;
    bit cap_prev, cap_last, comb_prev, nr_prev, nr_c, in_run, in_tail, comb, ad, run_e, clk_e, nr_eff, stall, take;
    logic [DW-1:0] cap_data;
    logic [AW-1:0] cap_addr;
    n = (cfg_len == 0) ? 4 : (cfg_len == 1) ? 8 : 16;
    gap = (cfg_gap == 0) ? 1 : int'(cfg_gap);
    phase = 1; tick_e = 0; cand = int'(cfg_first); widx = 0; tail_left = 0; run_start = -1; nstall = 0;
    cap_prev = 0; cap_last = 0; comb_prev = 1; nr_prev = 0; cap_data = '0; cap_addr = '0;
    @(posedge clk); #1;
    start = 1'b1; start_addr = a; nor_wait = ~cfg_wait_pol;
    @(posedge clk); #1;
    start = 1'b0;
    for (int c = 0; c < 400; c++) begin
      if (c > 0) begin @(posedge clk); #1; end
      nr_c = (stall_pct > 0) && (nstall < 40) && (($urandom % 100) < stall_pct);
      nor_wait = nr_c ? cfg_wait_pol : ~cfg_wait_pol;
      nor_data_in = word_at(c, salt);
      if (c == 3 && phase == 1) begin start = 1'b1; start_addr = ~a; end
      else start = 1'b0;
      in_run = (phase == 1); in_tail = (phase == 2);
      comb = !(in_run && tick_e >= int'(cfg_adv_on) && tick_e < int'(cfg_adv_off));
      ad = cfg_mux && in_run && (tick_e < int'(cfg_adv_off) + int'(cfg_adv_half));
      run_e = (in_run && tick_e >= int'(cfg_clk_act)) || in_tail;
      if (run_e && run_start < 0) run_start = c;
      rc = c - run_start;
      if (!run_e) clk_e = 0;
      else if (cfg_div == 0) clk_e = (rc >= 1);
      else if (cfg_div == 1) clk_e = (rc % 2 == 1);
      else clk_e = (rc % 4 >= 2);
      #2;
      check("R3/R9/R10 cs", nor_cs_n, !((in_run && tick_e >= int'(cfg_cs_on)) || in_tail));
      check("R4 adv first half", nor_adv_n, comb & (cfg_adv_half ? comb_prev : 1'b1));
      check("R11 bus drive", nor_ad_oe, ad);
      if (ad) check("R11 bus addr", nor_ad_out, a[DW-1:0]);
      check("R3/R11 oe", nor_oe_n, !(((in_run && tick_e >= int'(cfg_oe_on)) || in_tail) && !ad));
      check("R2 dev clk", nor_clk, clk_e);
      check("R5 valid", rd_valid, cap_prev);
      check("R10 done", done, cap_prev && cap_last);
      check("R1/R12 busy", busy, phase != 0);
      if (cap_prev) begin
        check("R5/R7/R8 data", rd_data, cap_data);
        check("R6 addr", rd_addr, cap_addr);
      end
      #4;
      check("R4 adv second half", nor_adv_n, comb);
      nr_eff = cfg_wait_early ? nr_prev : nr_c;
      stall = in_run && c == cand && nr_eff;
      take = in_run && c == cand && !nr_eff;
      if (stall) begin cand = c + 1; nstall++; end
      if (in_run && !stall) tick_e++;
      cap_prev = take;
      if (take) begin
        cap_data = word_at(c, salt);
        cap_addr = addr_of(a, widx, n, cfg_wrap);
        cap_last = (widx == n - 1);
        widx++;
        cand = c + gap;
        if (cap_last) begin phase = 2; tail_left = int'(cfg_cs_hold); end
      end else if (in_tail) begin
        if (tail_left == 0) phase = 0; else tail_left--;
      end else if (phase == 0 && !cap_prev) begin
        if (c > 0 && !in_run && !in_tail) break;
      end
      comb_prev = comb; nr_prev = nr_c;
    end
    start = 1'b0;
    idle_checks("post");
  endtask

  task automatic set_cfg(input logic [1:0] dv, input int act, input int cso, input int ao, input int af,
                         input bit hf, input int oe, input int fst, input int gp, input int hd,
                         input logic [1:0] ln, input bit wr, input bit pol, input bit early, input bit mx);
    cfg_div = dv; cfg_clk_act = TW'(act); cfg_cs_on = TW'(cso); cfg_adv_on = TW'(ao); cfg_adv_off = TW'(af);
    cfg_adv_half = hf; cfg_oe_on = TW'(oe); cfg_first = TW'(fst); cfg_gap = TW'(gp); cfg_cs_hold = TW'(hd);
    cfg_len = ln; cfg_wrap = wr; cfg_wait_pol = pol; cfg_wait_early = early; cfg_mux = mx;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #23 rst_n = 1'b1;
    #5;
    idle_checks("reset");
    set_cfg(2'd0, 1, 0, 0, 1, 1, 4, 10, 1, 1, 2'd2, 1, 0, 1, 1);
    burst(24'h12345B, 0, 1);
    set_cfg(2'd0, 1, 0, 0, 1, 1, 4, 10, 1, 1, 2'd2, 1, 1, 0, 1);
    burst(24'h00ABCE, 35, 2);
    set_cfg(2'd1, 3, 1, 0, 2, 0, 5, 6, 2, 0, 2'd0, 0, 0, 0, 0);
    burst(24'h0000FE, 20, 3);
    set_cfg(2'd2, 2, 0, 1, 3, 1, 3, 0, 0, 3, 2'd1, 1, 1, 1, 1);
    burst(24'hFFFFFD, 50, 4);
    for (int k = 0; k < 24; k++) begin
      int ao, af;
      ao = $urandom % 4; af = ao + 1 + ($urandom % 4);
      set_cfg(2'($urandom), $urandom % 16, $urandom % 4, ao, af, 1'($urandom), $urandom % 12,
              $urandom % 16, $urandom % 8, $urandom % 4, 2'($urandom), 1'($urandom),
              1'($urandom), 1'($urandom), 1'($urandom));
      burst(AW'($urandom), $urandom % 50, k + 10);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule